// File: doc/BRIEF.md
# Port-Mapped Keyboard Data Controller

This block sits on a simple processor-style bus and gives software access to key codes through two I/O port addresses: one for data and one for status and commands. A keyboard front end hands over one code byte at a time on a valid/ready stream. The block keeps that code in a single-byte holding buffer and reports through a status byte that new data is waiting. It also drives an interrupt request while the buffer holds an unread code.

The bus uses one-cycle read and write strobes. Alongside them it carries an address, write data, and a select line that tells I/O cycles apart from memory cycles. The block answers only I/O cycles that hit one of its two ports. Memory cycles are ignored, even when they carry the same address. Each decoded cycle is answered with a one-cycle ready pulse, and read data is presented with that pulse. Reading the data port empties the buffer, which drops the interrupt request. Reading the status port clears a sticky flag that records a lost code.

The front-end stream never stalls. `key_ready` is held high, so every beat offered with `key_valid` is taken in the cycle it is offered. A beat that finds the buffer still full is discarded, and the loss is recorded in the overrun flag. A producer therefore needs no back-pressure handling. Lost codes are reported to software instead.

Top module: `kbd_port_ctrl`

## Requirements
- R1: After reset the buffer is empty, the overrun flag is clear, `irq` and `bus_rdy` are low, and the command byte is 0x01, so the interrupt is enabled.
- R2: Only cycles with `bus_io`=1 whose address equals 0x60 (data port) or 0x64 (status/command port) are answered. Memory cycles (`bus_io`=0) and I/O cycles to any other address produce no ready pulse and change no state.
- R3: `key_ready` is always high. A beat with `key_valid`=1 that arrives while the buffer is empty is stored, and the buffer-full flag is set on the following clock edge.
- R4: An I/O read of 0x60 returns the most recently stored code and clears the buffer-full flag. A read while the buffer is empty returns the last code again.
- R5: An I/O read of 0x64 returns a status byte. Bit 0 is buffer full, bit 1 is overrun, and bits 7..2 are zero. The read clears the overrun flag.
- R6: A beat that arrives while the buffer is full, with no data-port read in the same cycle, is dropped and sets the overrun flag. If that setting coincides with a status read, the setting wins.
- R7: `irq` is high exactly when the buffer is full and bit 0 of the command byte is 1.
- R8: An I/O write to 0x64 stores `bus_wdata` as the command byte. An I/O write to 0x60 is acknowledged but has no effect.
- R9: `bus_rdy` is a single-cycle pulse in the clock cycle after a decoded strobe is sampled. `bus_rdata` carries the read result during that pulse, and is zero during write acknowledgements and whenever `bus_rdy` is low.
- R10: A beat that arrives in the same cycle as a data-port read is stored without overrun. The read returns the previous code, and the buffer stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Port or memory address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_io | input | 1 | 1 marks an I/O cycle, 0 marks a memory cycle |
| bus_rdata | output | 8 | Read data, valid while bus_rdy is high |
| bus_rdy | output | 1 | Cycle-complete pulse |
| key_valid | input | 1 | Front-end code beat valid |
| key_code | input | 8 | Front-end code byte |
| key_ready | output | 1 | Always high; beats are never stalled |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives memory cycles and off-address I/O cycles at the port addresses. A decoder that ignored the I/O select line would answer these cycles and empty the buffer. The bench also offers a second code while the first is unread. A design that overwrote the buffer would return the newer code and leave overrun clear. It then collides a code beat with a data-port read and with a status read. A wrong ordering of these events would either report a false overrun and lose the new code, or erase an overrun that had just occurred. Finally, it toggles the interrupt enable while a code is pending, to show that the request follows the enable and the full flag and nothing else.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int BYTE_W   = 8;
  localparam int ST_FULL  = 0;
  localparam int ST_OVR   = 1;
  localparam int CMD_IRQE = 0;
endpackage

// File: rtl/kbd_decode.sv
module kbd_decode #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] DATA_PORT = 16'h0060,
  parameter logic [15:0] CTRL_PORT = 16'h0064
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              io,
  output logic              data_rd,
  output logic              stat_rd,
  output logic              cmd_wr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] DP = ADDR_W'(DATA_PORT);
  localparam logic [ADDR_W-1:0] CP = ADDR_W'(CTRL_PORT);

  logic sel_data, sel_ctrl;

  always_comb begin
    sel_data = io && (addr == DP);
    sel_ctrl = io && (addr == CP);
    data_rd  = sel_data && rd;
    stat_rd  = sel_ctrl && rd;
    cmd_wr   = sel_ctrl && wr;
    hit      = (sel_data || sel_ctrl) && (rd || wr);
  end
endmodule

// File: rtl/kbd_buffer.sv
module kbd_buffer
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [BYTE_W-1:0] key_code,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] code,
  output logic              full,
  output logic              ovr
);
  logic accept;
  assign accept = key_valid && (!full || data_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (accept) begin
        code <= key_code;
        full <= 1'b1;
      end else if (data_rd) begin
        full <= 1'b0;
      end
      if (key_valid && !accept) ovr <= 1'b1;
      else if (stat_rd)         ovr <= 1'b0;
    end
  end

  // R3
  store_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !full) |=> (full && code == $past(key_code)));
  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !key_valid) |=> !full);
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && full && !data_rd) |=> (ovr && $stable(code)));
  // R10
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && data_rd) |=> (full && $stable(ovr)));
endmodule

// File: rtl/kbd_bus_resp.sv
module kbd_bus_resp
  import kbd_pkg::*;
#(
  parameter logic [7:0] CMD_RESET = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              data_rd,
  input  logic              stat_rd,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] code,
  input  logic              full,
  input  logic              ovr,
  output logic [BYTE_W-1:0] rdata,
  output logic              rdy,
  output logic [BYTE_W-1:0] cmd
);
  logic [BYTE_W-1:0] status;

  always_comb begin
    status         = '0;
    status[ST_FULL] = full;
    status[ST_OVR]  = ovr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      rdy   <= 1'b0;
      cmd   <= CMD_RESET;
    end else begin
      rdy <= hit;
      if (data_rd)      rdata <= code;
      else if (stat_rd) rdata <= status;
      else              rdata <= '0;
      if (cmd_wr) cmd <= wdata;
    end
  end

  // R9
  rdy_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rdy);
  // R9
  rdy_only_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> $past(hit));
endmodule

// File: rtl/kbd_port_ctrl.sv
module kbd_port_ctrl
  import kbd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] DATA_PORT = 16'h0060,
  parameter logic [15:0] CTRL_PORT = 16'h0064,
  parameter logic [7:0]  CMD_RESET = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_io,
  output logic [7:0]        bus_rdata,
  output logic              bus_rdy,
  input  logic              key_valid,
  input  logic [7:0]        key_code,
  output logic              key_ready,
  output logic              irq
);
  logic data_rd, stat_rd, cmd_wr, hit, full, ovr;
  logic [BYTE_W-1:0] code, cmd;

  kbd_decode #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CTRL_PORT(CTRL_PORT)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .io(bus_io),
    .data_rd(data_rd), .stat_rd(stat_rd), .cmd_wr(cmd_wr), .hit(hit)
  );

  kbd_buffer u_buf (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .data_rd(data_rd), .stat_rd(stat_rd), .code(code), .full(full), .ovr(ovr)
  );

  kbd_bus_resp #(.CMD_RESET(CMD_RESET)) u_resp (
    .clk(clk), .rst_n(rst_n), .hit(hit), .data_rd(data_rd), .stat_rd(stat_rd),
    .cmd_wr(cmd_wr), .wdata(bus_wdata), .code(code), .full(full), .ovr(ovr),
    .rdata(bus_rdata), .rdy(bus_rdy), .cmd(cmd)
  );

  assign key_ready = 1'b1;
  assign irq       = full && cmd[CMD_IRQE];

  // R7
  irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> full);
  // R2
  mem_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_io && !key_valid) |=> ($stable(full) && $stable(ovr) && !bus_rdy));
  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy |-> (bus_rdata == 8'h00));
endmodule

// File: tb/kbd_port_ctrl_test.sv
module kbd_port_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 0, bus_wr = 0, bus_io = 0;
  logic [7:0]  bus_rdata;
  logic        bus_rdy;
  logic        key_valid = 0;
  logic [7:0]  key_code = '0;
  logic        key_ready;
  logic        irq;

  int tests = 0, fails = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #4 clk = ~clk;

  kbd_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .key_valid(key_valid), .key_code(key_code),
    .key_ready(key_ready), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data on each ready pulse
  always @(negedge clk) if (rst_n && !done && bus_rdy) begin
    tests++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R2 unexpected ready actual=1 expected=0");
    end else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s rdata actual=%0h expected=%0h", t, bus_rdata, e);
      end
    end
  end

  task automatic cyc(input bit rd, input bit wr, input bit io, input logic [15:0] a,
                     input logic [7:0] wd, input bit answer, input logic [7:0] exp,
                     input string req, input bit with_key = 0, input logic [7:0] kc = 0);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_io = io; bus_addr = a; bus_wdata = wd;
    if (with_key) begin key_valid = 1; key_code = kc; end
    if (answer) begin exp_q.push_back(exp); tag_q.push_back(req); end
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_io = 0; key_valid = 0;
    @(negedge clk);
    check({req, " pending"}, exp_q.size(), 0);
  endtask

  task automatic push_key(input logic [7:0] c);
    @(negedge clk); key_valid = 1; key_code = c;
    @(negedge clk); key_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", irq, 0);
    check("R1 rdy", bus_rdy, 0);
    check("R3 key_ready", key_ready, 1);
    cyc(1,0,1,16'h64,0,1,8'h00,"R1 status");
    push_key(8'h1C);
    check("R7 irq on full", irq, 1);
    cyc(1,0,0,16'h60,0,0,0,"R2 mem read data");
    cyc(1,0,0,16'h64,0,0,0,"R2 mem read status");
    cyc(1,0,1,16'h61,0,0,0,"R2 other port");
    cyc(1,0,1,16'h64,0,1,8'h01,"R3 status full");
    cyc(1,0,1,16'h60,0,1,8'h1C,"R4 data read");
    check("R4 irq cleared", irq, 0);
    cyc(1,0,1,16'h64,0,1,8'h00,"R4 status empty");
    cyc(1,0,1,16'h60,0,1,8'h1C,"R4 reread empty");
    push_key(8'h2A);
    push_key(8'h3B);
    cyc(1,0,1,16'h64,0,1,8'h03,"R6 overrun");
    cyc(1,0,1,16'h64,0,1,8'h01,"R5 ovr cleared");
    cyc(1,0,1,16'h60,0,1,8'h2A,"R6 dropped code");
    cyc(0,1,1,16'h64,8'h00,1,8'h00,"R8 cmd off");
    push_key(8'h45);
    check("R7 irq disabled", irq, 0);
    cyc(0,1,1,16'h64,8'h01,1,8'h00,"R8 cmd on");
    check("R7 irq enabled", irq, 1);
    cyc(0,1,0,16'h64,8'h00,0,0,"R2 mem write");
    check("R2 irq kept", irq, 1);
    cyc(0,1,1,16'h60,8'hEE,1,8'h00,"R8 data write");
    cyc(1,0,1,16'h60,0,1,8'h45,"R8 data unchanged");
    cyc(1,0,1,16'h60,0,1,8'h45,"R10 collide empty",1,8'h66);
    cyc(1,0,1,16'h64,0,1,8'h01,"R10 full after");
    cyc(1,0,1,16'h60,0,1,8'h66,"R10 collide full",1,8'h71);
    cyc(1,0,1,16'h64,0,1,8'h01,"R10 no overrun");
    cyc(1,0,1,16'h64,0,1,8'h01,"R6 set wins",1,8'h72);
    cyc(1,0,1,16'h64,0,1,8'h03,"R6 ovr stuck");
    cyc(1,0,1,16'h60,0,1,8'h71,"R4 final code");
    check("R9 rdy idle", bus_rdy, 0);
    check("R9 rdata idle", bus_rdata, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule